// File: doc/BRIEF.md
# Legacy DMA channel register file

This block is the byte-wide, port-mapped register bank of one four-channel DMA controller. For each channel it keeps a 16-bit base address, a 16-bit base count, a current address and a current count. Shared by all channels are a command register, a mask register, a status byte, and a byte-pointer flip-flop that chooses which byte of a 16-bit channel register a single byte access touches. The 8-bit or 16-bit controller variant is chosen by the parameter `SHIFT` (0 or 1). This parameter shifts the port decode and scales the current address and current count.

Software reaches the bank through one access strobe with a write flag, a port address and a data byte. The read byte is combinational and reflects the state before the clock edge that ends the access. The transfer engine next to the bank is served by two things. First, it receives the command, mask, request bits and channel modes as outputs. Second, it reports transfer progress on `step_in` and terminal counts on `tc_in`. Several control ports act as commands rather than stores.

Top module: `dma_chan_regfile`

## Requirements
- R1: The port index is bits [3:0] of `acc_addr >> SHIFT`. Higher address bits are ignored, and so are the bits below `SHIFT`. Indices 0..7 select channel `index>>1`. Index bit 0 selects the address register (0) or the count register (1).
- R2: Every channel-register access (index 0..7), read or write, toggles one shared byte-pointer flip-flop. The flip-flop resets to 0. When it is 0 the access uses bits [7:0]; when it is 1 the access uses bits [15:8].
- R3: A high-byte write to a base register loads the current address with the base address shifted left by `SHIFT`. It also clears that channel's current count. A low-byte write leaves both current values unchanged.
- R4: A count read returns the byte of `((base_count << SHIFT) - current_count) mod 2^17`. The value is shifted right by `SHIFT + 8*flipflop` before the byte is taken.
- R5: An address read returns `current_address + current_count` taken modulo 2^17. When bit 5 of the channel's mode is 1 the count is subtracted instead. The byte is selected as in R4. A 1 on `step_in[c]` increments channel c's current count. A high-byte write to channel c in the same cycle takes precedence over the increment.
- R6: A write to index 8 loads the command register only when `data & 8'hFB == 0`, which accepts 0x00 and 0x04. Any other value leaves `cmd_o` unchanged.
- R7: A write to index 9 sets request bit `data[1:0]` (`req_o`, status bit 4+ch) to `data[2]`. It also clears terminal-count bit `data[1:0]` (status bit ch).
- R8: A write to index 0xA sets mask bit `data[1:0]` to `data[2]`. A write to 0xE clears all four mask bits. A write to 0xF loads the mask with `data[3:0]`.
- R9: A write to index 0xB stores the whole byte as the mode of channel `data[1:0]`. The mode appears on `mode_o[8c+7:8c]`.
- R10: A write to index 0xC clears the flip-flop. A write to 0xD clears the flip-flop, sets all mask bits, and clears status and command.
- R11: A read of index 8 returns the status byte `{req[3:0], tc[3:0]}` and then clears the terminal-count nibble. A 1 on `tc_in[c]` sets tc bit c, and this set takes precedence over any clear in the same cycle.
- R12: A read of index 0xF returns `{4'b0, mask}`. Reads of indices 9..0xE return 0. `rd_data` is 0 in every cycle that is not a read.
- R13: Reset acts like a master clear. In addition it zeroes every base register, current register and mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Port access strobe, one cycle per access |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Port address |
| acc_wdata | input | 8 | Write byte |
| tc_in | input | 4 | Terminal-count pulse per channel |
| step_in | input | 4 | Current-count increment per channel |
| rd_data | output | 8 | Read byte for the current access |
| cmd_o | output | 8 | Command register |
| mask_o | output | 4 | Channel mask bits |
| req_o | output | 4 | Software request bits |
| mode_o | output | 32 | Four packed channel mode bytes |

## Verification
Two instances run the same stimulus side by side, one with each width shift, and junk address bits are added. Agreement between the instances therefore shows that decode and scaling depend only on `SHIFT`. Channel accesses are interleaved across channels and register types, so a per-register byte pointer would read the wrong byte, unlike the shared one. Steps near a base of 0xFFFF and mode changes to decrement separate the add, subtract and 17-bit wrap paths. Status reads with coincident terminal-count pulses, and command values with one rejected bit each, expose errors in precedence and filtering.

// File: rtl/dma_rf_pkg.sv
package dma_rf_pkg;
  localparam int NCH      = 4;
  localparam int CH_W     = 2;
  localparam int BASE_W   = 16;
  localparam int CUR_W    = BASE_W + 1;
  localparam int MODE_DEC = 5;

  localparam logic [3:0] IDX_CMD    = 4'h8;
  localparam logic [3:0] IDX_REQ    = 4'h9;
  localparam logic [3:0] IDX_SMASK  = 4'hA;
  localparam logic [3:0] IDX_MODE   = 4'hB;
  localparam logic [3:0] IDX_FFCLR  = 4'hC;
  localparam logic [3:0] IDX_MCLR   = 4'hD;
  localparam logic [3:0] IDX_MZERO  = 4'hE;
  localparam logic [3:0] IDX_MLOAD  = 4'hF;

  localparam logic [7:0] CMD_REJECT = 8'hFB;
endpackage

// File: rtl/dma_rf_chan.sv
module dma_rf_chan
  import dma_rf_pkg::*;
#(
  parameter int SHIFT = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       sel_cnt,
  input  logic       hi_byte,
  input  logic [7:0] wdata,
  input  logic       step,
  input  logic       dec_mode,
  output logic [7:0] rd_byte
);
  logic [BASE_W-1:0] base_a_q, base_a_d, base_c_q, base_c_d;
  logic [CUR_W-1:0]  cur_a_q, cur_a_d, cur_c_q, cur_c_d;
  logic              base_en, cur_en;
  logic [CUR_W-1:0]  cnt_val, addr_val, pick, shifted;

  always_comb begin
    base_a_d = base_a_q;
    base_c_d = base_c_q;
    cur_a_d  = cur_a_q;
    cur_c_d  = cur_c_q;
    base_en  = wr_en;
    cur_en   = 1'b0;
    if (wr_en) begin
      if (!hi_byte) begin
        if (sel_cnt) base_c_d[7:0] = wdata;
        else         base_a_d[7:0] = wdata;
      end else begin
        if (sel_cnt) base_c_d[15:8] = wdata;
        else         base_a_d[15:8] = wdata;
        cur_a_d = CUR_W'({1'b0, base_a_d}) << SHIFT;
        cur_c_d = '0;
        cur_en  = 1'b1;
      end
    end
    if (step && !(wr_en && hi_byte)) begin
      cur_c_d = cur_c_q + CUR_W'(1);
      cur_en  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_a_q <= '0;
      base_c_q <= '0;
    end else if (base_en) begin
      base_a_q <= base_a_d;
      base_c_q <= base_c_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_a_q <= '0;
      cur_c_q <= '0;
    end else if (cur_en) begin
      cur_a_q <= cur_a_d;
      cur_c_q <= cur_c_d;
    end
  end

  always_comb begin
    cnt_val  = (CUR_W'({1'b0, base_c_q}) << SHIFT) - cur_c_q;
    addr_val = dec_mode ? (cur_a_q - cur_c_q) : (cur_a_q + cur_c_q);
    pick     = sel_cnt ? cnt_val : addr_val;
    shifted  = hi_byte ? (pick >> (SHIFT + 8)) : (pick >> SHIFT);
    rd_byte  = shifted[7:0];
  end
endmodule

// File: rtl/dma_rf_ctrl.sv
module dma_rf_ctrl
  import dma_rf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chan_acc,
  input  logic             ctl_wr,
  input  logic             stat_rd,
  input  logic [3:0]       idx,
  input  logic [7:0]       wdata,
  input  logic [NCH-1:0]   tc_in,
  output logic             ff_q,
  output logic [7:0]       cmd_q,
  output logic [NCH-1:0]   mask_q,
  output logic [NCH-1:0]   req_q,
  output logic [NCH-1:0]   tcf_q,
  output logic [NCH*8-1:0] mode_flat
);
  logic             ff_d;
  logic [7:0]       cmd_d;
  logic [NCH-1:0]   mask_d, req_d, tcf_d;
  logic [7:0]       mode_q [NCH];
  logic [7:0]       mode_d [NCH];
  logic [CH_W-1:0]  sel_ch;

  always_comb begin
    ff_d   = ff_q;
    cmd_d  = cmd_q;
    mask_d = mask_q;
    req_d  = req_q;
    tcf_d  = tcf_q;
    for (int c = 0; c < NCH; c++) mode_d[c] = mode_q[c];
    sel_ch = wdata[CH_W-1:0];
    if (chan_acc) ff_d = ~ff_q;
    if (stat_rd) tcf_d = '0;
    if (ctl_wr) begin
      case (idx)
        IDX_CMD:   if ((wdata & CMD_REJECT) == 8'h00) cmd_d = wdata;
        IDX_REQ: begin
          req_d[sel_ch] = wdata[2];
          tcf_d[sel_ch] = 1'b0;
        end
        IDX_SMASK: mask_d[sel_ch] = wdata[2];
        IDX_MODE:  mode_d[sel_ch] = wdata;
        IDX_FFCLR: ff_d = 1'b0;
        IDX_MCLR: begin
          ff_d   = 1'b0;
          mask_d = '1;
          req_d  = '0;
          tcf_d  = '0;
          cmd_d  = '0;
        end
        IDX_MZERO: mask_d = '0;
        IDX_MLOAD: mask_d = wdata[NCH-1:0];
        default: ;
      endcase
    end
    tcf_d = tcf_d | tc_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ff_q   <= 1'b0;
      cmd_q  <= '0;
      mask_q <= '1;
      req_q  <= '0;
      tcf_q  <= '0;
      for (int c = 0; c < NCH; c++) mode_q[c] <= '0;
    end else begin
      ff_q   <= ff_d;
      cmd_q  <= cmd_d;
      mask_q <= mask_d;
      req_q  <= req_d;
      tcf_q  <= tcf_d;
      for (int c = 0; c < NCH; c++) mode_q[c] <= mode_d[c];
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_mode
    assign mode_flat[g*8 +: 8] = mode_q[g];
  end
endmodule

// File: rtl/dma_chan_regfile.sv
module dma_chan_regfile
  import dma_rf_pkg::*;
#(
  parameter int SHIFT  = 0,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [7:0]        acc_wdata,
  input  logic [NCH-1:0]    tc_in,
  input  logic [NCH-1:0]    step_in,
  output logic [7:0]        rd_data,
  output logic [7:0]        cmd_o,
  output logic [NCH-1:0]    mask_o,
  output logic [NCH-1:0]    req_o,
  output logic [NCH*8-1:0]  mode_o
);
  logic [3:0]     idx;
  logic           chan_acc, ctl_wr, stat_rd, ff;
  logic [NCH-1:0] tcf;
  logic [7:0]     chan_byte [NCH];

  assign idx      = 4'(acc_addr >> SHIFT);
  assign chan_acc = acc_en & ~idx[3];
  assign ctl_wr   = acc_en & acc_wr & idx[3];
  assign stat_rd  = acc_en & ~acc_wr & (idx == IDX_CMD);

  dma_rf_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .chan_acc  (chan_acc),
    .ctl_wr    (ctl_wr),
    .stat_rd   (stat_rd),
    .idx       (idx),
    .wdata     (acc_wdata),
    .tc_in     (tc_in),
    .ff_q      (ff),
    .cmd_q     (cmd_o),
    .mask_q    (mask_o),
    .req_q     (req_o),
    .tcf_q     (tcf),
    .mode_flat (mode_o)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    dma_rf_chan #(.SHIFT(SHIFT)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (chan_acc & acc_wr & (idx[2:1] == CH_W'(g))),
      .sel_cnt  (idx[0]),
      .hi_byte  (ff),
      .wdata    (acc_wdata),
      .step     (step_in[g]),
      .dec_mode (mode_o[g*8 + MODE_DEC]),
      .rd_byte  (chan_byte[g])
    );
  end

  always_comb begin
    rd_data = 8'h00;
    if (acc_en && !acc_wr) begin
      if (!idx[3])               rd_data = chan_byte[idx[2:1]];
      else if (idx == IDX_CMD)   rd_data = {req_o, tcf};
      else if (idx == IDX_MLOAD) rd_data = {4'b0000, mask_o};
    end
  end
endmodule

// File: rtl/dma_rf_chk.sv
module dma_rf_chk #(
  parameter int SHIFT  = 0,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_en,
  input logic              acc_wr,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [7:0]        acc_wdata,
  input logic [7:0]        rd_data,
  input logic [7:0]        cmd_o,
  input logic [3:0]        mask_o,
  input logic [3:0]        req_o
);
  logic [3:0] ix;
  logic       wr_ev, rd_ev;
  assign ix    = 4'(acc_addr >> SHIFT);
  assign wr_ev = acc_en & acc_wr;
  assign rd_ev = acc_en & ~acc_wr;

  assert_cmd_filter_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ev && ix == 4'h8 && (acc_wdata & 8'hFB) != 8'h00) |=> $stable(cmd_o));

  assert_req_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ev && ix == 4'h9) |=> req_o[$past(acc_wdata[1:0])] == $past(acc_wdata[2]));

  assert_single_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ev && ix == 4'hA) |=> mask_o[$past(acc_wdata[1:0])] == $past(acc_wdata[2]));

  assert_mask_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ev && ix == 4'hE) |=> mask_o == 4'h0);

  assert_master_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ev && ix == 4'hD) |=> (mask_o == 4'hF && cmd_o == 8'h00 && req_o == 4'h0));

  assert_idle_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_ev || (ix > 4'h8 && ix < 4'hF)) |-> rd_data == 8'h00);
endmodule

bind dma_chan_regfile dma_rf_chk #(.SHIFT(SHIFT), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_en    (acc_en),
  .acc_wr    (acc_wr),
  .acc_addr  (acc_addr),
  .acc_wdata (acc_wdata),
  .rd_data   (rd_data),
  .cmd_o     (cmd_o),
  .mask_o    (mask_o),
  .req_o     (req_o)
);

// File: tb/dma_chan_regfile_tb_top.sv
module dma_chan_regfile_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n, en, wr;
  logic [3:0] tc, st;
  logic [7:0] wd, addr0, addr1;
  logic [7:0] rd0, rd1, cmd0, cmd1;
  logic [3:0] mk0, mk1, rq0, rq1;
  logic [31:0] md0, md1;
  int cur_idx;
  int errors = 0, checks = 0;

  dma_chan_regfile #(.SHIFT(0), .ADDR_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .acc_en(en), .acc_wr(wr), .acc_addr(addr0),
    .acc_wdata(wd), .tc_in(tc), .step_in(st), .rd_data(rd0), .cmd_o(cmd0),
    .mask_o(mk0), .req_o(rq0), .mode_o(md0));

  dma_chan_regfile #(.SHIFT(1), .ADDR_W(8)) dut_w_i (
    .clk(clk), .rst_n(rst_n), .acc_en(en), .acc_wr(wr), .acc_addr(addr1),
    .acc_wdata(wd), .tc_in(tc), .step_in(st), .rd_data(rd1), .cmd_o(cmd1),
    .mask_o(mk1), .req_o(rq1), .mode_o(md1));

  // behavioural reference, one set per width shift u (u is also the shift)
  int m_ba[2][4], m_bc[2][4], m_ca[2][4], m_cc[2][4], m_md[2][4];
  int m_mask[2], m_stat[2], m_cmd[2], m_ff[2];

  task automatic m_reset();
    for (int u = 0; u < 2; u++) begin
      for (int c = 0; c < 4; c++) begin
        m_ba[u][c] = 0; m_bc[u][c] = 0; m_ca[u][c] = 0; m_cc[u][c] = 0; m_md[u][c] = 0;
      end
      m_mask[u] = 15; m_stat[u] = 0; m_cmd[u] = 0; m_ff[u] = 0;
    end
  endtask

  function automatic int m_read(int u, int i);
    int ch, v;
    ch = i >> 1;
    if (i < 8) begin
      if (i % 2 == 1) v = ((m_bc[u][ch] << u) - m_cc[u][ch]) & 'h1FFFF;
      else if (((m_md[u][ch] >> 5) & 1) == 1) v = (m_ca[u][ch] - m_cc[u][ch]) & 'h1FFFF;
      else v = (m_ca[u][ch] + m_cc[u][ch]) & 'h1FFFF;
      return (v >> (u + 8 * m_ff[u])) & 255;
    end
    if (i == 8) return m_stat[u];
    if (i == 15) return m_mask[u];
    return 0;
  endfunction

  task automatic m_apply(int u);
    int ch, rch, wdi, req, tcn;
    bit hiw;
    hiw = 0; wdi = int'(wd); ch = wdi & 3; rch = cur_idx >> 1;
    req = m_stat[u] >> 4; tcn = m_stat[u] & 15;
    if (en) begin
      if (cur_idx < 8) begin
        if (wr) begin
          if (m_ff[u] == 0) begin
            if (cur_idx % 2 == 1) m_bc[u][rch] = (m_bc[u][rch] & 'hFF00) | wdi;
            else                  m_ba[u][rch] = (m_ba[u][rch] & 'hFF00) | wdi;
          end else begin
            if (cur_idx % 2 == 1) m_bc[u][rch] = (m_bc[u][rch] & 'hFF) | (wdi << 8);
            else                  m_ba[u][rch] = (m_ba[u][rch] & 'hFF) | (wdi << 8);
            m_ca[u][rch] = (m_ba[u][rch] << u) & 'h1FFFF;
            m_cc[u][rch] = 0;
            hiw = 1;
          end
        end
        m_ff[u] = 1 - m_ff[u];
      end else if (wr) begin
        case (cur_idx)
          8:  if ((wdi & 'hFB) == 0) m_cmd[u] = wdi;
          9:  begin
                if ((wdi & 4) != 0) req = req | (1 << ch); else req = req & ~(1 << ch);
                tcn = tcn & ~(1 << ch);
              end
          10: if ((wdi & 4) != 0) m_mask[u] = m_mask[u] | (1 << ch);
              else m_mask[u] = m_mask[u] & ~(1 << ch);
          11: m_md[u][ch] = wdi;
          12: m_ff[u] = 0;
          13: begin m_ff[u] = 0; m_mask[u] = 15; req = 0; tcn = 0; m_cmd[u] = 0; end
          14: m_mask[u] = 0;
          15: m_mask[u] = wdi & 15;
          default: ;
        endcase
      end else if (cur_idx == 8) tcn = 0;
    end
    for (int c = 0; c < 4; c++)
      if (st[c] && !(hiw && rch == c)) m_cc[u][c] = (m_cc[u][c] + 1) & 'h1FFFF;
    tcn = tcn | int'(tc);
    m_stat[u] = (req << 4) | tcn;
  endtask

  task automatic chk(string tag, string what, int u, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s shift=%0d actual=%0h expected=%0h", tag, what, u, act, exp);
    end
  endtask

  task automatic compare_all(string tag);
    for (int u = 0; u < 2; u++) begin
      chk(tag, "rd_data", u, int'(u == 0 ? rd0 : rd1), (en && !wr) ? m_read(u, cur_idx) : 0);
      chk(tag, "cmd", u, int'(u == 0 ? cmd0 : cmd1), m_cmd[u]);
      chk(tag, "mask", u, int'(u == 0 ? mk0 : mk1), m_mask[u]);
      chk(tag, "req", u, int'(u == 0 ? rq0 : rq1), m_stat[u] >> 4);
      for (int c = 0; c < 4; c++)
        chk(tag, "mode", u, int'(u == 0 ? md0[c*8 +: 8] : md1[c*8 +: 8]), m_md[u][c]);
    end
  endtask

  task automatic op(string tag, bit e, bit w, int i, int d, int t = 0, int s = 0);
    @(negedge clk);
    en = e; wr = w; cur_idx = i; wd = 8'(d); tc = 4'(t); st = 4'(s);
    addr0 = 8'(i | 'h40);
    addr1 = 8'((i << 1) | 1 | 'h40);
    #2;
    compare_all(tag);
    @(posedge clk);
    m_apply(0);
    m_apply(1);
  endtask

  task automatic idle(string tag);
    op(tag, 0, 0, 0, 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; en = 1'b0; wr = 1'b0; tc = '0; st = '0;
    m_reset();
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  bit done = 0;
  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; en = 0; wr = 0; wd = 0; tc = 0; st = 0; cur_idx = 0; addr0 = 0; addr1 = 0;
    m_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    idle("R13");
    op("R12", 1, 0, 15, 0);                 // mask reads FF-less 0x0F after reset
    // R1 R2 R3: base address of channel 1, low then high byte
    op("R2", 1, 1, 2, 'h34);
    op("R3", 1, 1, 2, 'h12);
    op("R1", 1, 0, 2, 0);
    op("R2", 1, 0, 2, 0);
    // R4: base count of channel 1
    op("R4", 1, 1, 3, 'h10);
    op("R4", 1, 1, 3, 'h00);
    op("R4", 1, 0, 3, 0);
    op("R4", 1, 0, 3, 0);
    // R5: increments, then address and count reads
    op("R5", 0, 0, 0, 0, 0, 'b0010);
    op("R5", 0, 0, 0, 0, 0, 'b0010);
    op("R5", 0, 0, 0, 0, 0, 'b0011);
    op("R5", 1, 0, 2, 0);
    op("R5", 1, 0, 2, 0);
    op("R4", 1, 0, 3, 0);
    op("R4", 1, 0, 3, 0);
    // R9 R5: decrement mode on channel 1
    op("R9", 1, 1, 11, 'h21);
    op("R5", 1, 0, 2, 0);
    op("R5", 1, 0, 2, 0);
    op("R9", 1, 1, 11, 'h46);
    // R3: low-byte write keeps current values; R10 clear pointer
    op("R3", 1, 1, 2, 'h99);
    op("R10", 1, 1, 12, 0);
    op("R3", 1, 0, 2, 0);
    op("R10", 1, 1, 12, 0);
    // R2: pointer shared across channels
    op("R2", 1, 1, 0, 'hAB);
    op("R2", 1, 0, 3, 0);
    op("R2", 1, 0, 6, 0);
    op("R2", 1, 0, 6, 0);
    // R5: 17-bit wrap on channel 3, step coinciding with high write
    op("R10", 1, 1, 12, 0);
    op("R5", 1, 1, 6, 'hFF);
    op("R5", 1, 1, 6, 'hFF, 0, 'b1000);
    op("R5", 0, 0, 0, 0, 0, 'b1000);
    op("R5", 0, 0, 0, 0, 0, 'b1000);
    op("R5", 1, 0, 6, 0);
    op("R5", 1, 0, 6, 0);
    op("R4", 1, 0, 7, 0);
    op("R4", 1, 0, 7, 0);
    // R6: command filter
    op("R6", 1, 1, 8, 'h04);
    op("R6", 1, 1, 8, 'h05);
    op("R6", 1, 1, 8, 'h80);
    op("R6", 1, 1, 8, 'h00);
    op("R6", 1, 1, 8, 'h14);
    // R7 R11: requests and terminal counts
    op("R7", 1, 1, 9, 'h06);
    op("R7", 1, 1, 9, 'h07);
    op("R11", 0, 0, 0, 0, 'b1010);
    op("R7", 1, 1, 9, 'h01);
    op("R11", 1, 0, 8, 0);
    op("R11", 1, 0, 8, 0);
    op("R11", 0, 0, 0, 0, 'b0101);
    op("R11", 1, 0, 8, 0, 'b0001);
    op("R11", 1, 0, 8, 0);
    op("R7", 1, 1, 9, 'h02);
    // R8: mask operations
    op("R8", 1, 1, 14, 0);
    op("R8", 1, 1, 10, 'h05);
    op("R8", 1, 1, 10, 'h07);
    op("R8", 1, 1, 10, 'h01);
    op("R8", 1, 1, 15, 'hA5);
    op("R12", 1, 0, 15, 0);
    // R12: other control reads are zero
    for (int i = 9; i < 15; i++) op("R12", 1, 0, i, 0);
    // R10: master clear
    op("R10", 1, 1, 9, 'h05);
    op("R10", 1, 1, 0, 'h11);
    op("R10", 1, 1, 13, 0);
    op("R10", 1, 0, 0, 0);
    op("R10", 1, 0, 8, 0);
    // R13: reset mid-run
    op("R13", 1, 1, 4, 'h77);
    op("R13", 1, 1, 11, 'h22);
    do_reset();
    idle("R13");
    op("R13", 1, 0, 4, 0);
    op("R13", 1, 0, 4, 0);
    idle("R13");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule